// File: doc/BRIEF.md
# Serial Transmit Frame Synchronizer

This block drives the data line of a frame-synchronized serial transmitter. Its clock is the bit clock. A producer holds one parallel element in a holding register. When a frame sync pulse is sampled while the block is idle, the block takes that element and waits a programmable number of bit clocks, holding the line at its idle level. It then shifts the element out, most significant bit first, one bit per clock.

A frame sync pulse that is sampled while a frame is still in progress (during its delay or its data bits) is early. A control input chooses what happens to an early pulse. It is either dropped, so the frame runs on untouched, or it aborts the frame. On an abort, a sticky sync error flag is set and the same element is sent again from its first bit, after the data delay counted from the early pulse. The holding register is handed back to the producer only when an element goes out complete. If no element is waiting when a frame starts, the previous element is sent again and a sticky underflow flag is raised.

Top module: `tfs_tx_framer`

## Requirements
- R1: After reset, `tx_data` is 0 (the idle level), and `tx_busy`, `hold_release`, `sync_err` and `underflow` are all 0.
- R2: A frame sync sampled at a rising edge while `tx_busy` is 0 starts a frame using the delay D = `data_delay`, where a value of 3 is treated as 2. `tx_busy` is 1 from the cycle after that edge. `tx_data` stays at 0 for the D cycles after that edge, and the first data bit appears in the cycle after edge D.
- R3: A frame's element goes out most significant bit first, one bit per cycle over W = 8 consecutive cycles, and `tx_data` is 0 whenever no data bit is being sent.
- R4: A frame sync is early when it is sampled at any edge while `tx_busy` is 1. This includes the edge that ends the last data bit, so the earliest accepted sync falls one cycle after the last bit.
- R5: With `skip_early` = 1, an early sync changes nothing: the frame's bits, `tx_busy`, `hold_release` and `sync_err` carry on exactly as without it.
- R6: With `skip_early` = 0, an early sync aborts the frame. The same element then restarts from its MSB after D idle cycles, counted from the early edge with D taken from `data_delay` at that edge.
- R7: `sync_err` is set in the cycle after an abort and holds until an `err_clear` pulse or reset clears it. If an abort and `err_clear` fall on the same edge, the set wins.
- R8: `hold_release` is 1 for exactly the cycle in which the last data bit of an element taken from the holding register is on `tx_data`. An aborted attempt does not raise it, and neither does a frame that resends an old element.
- R9: A frame started while `hold_valid` is 0 resends the last element taken (0 after reset) and sets the sticky `underflow` flag. `underflow` is cleared by `err_clear` or reset, and a set on the same edge wins.
- R10: `tx_busy` falls in the cycle after the last data bit, unless a restart keeps the frame going.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_in | input | 1 | Frame sync pulse |
| skip_early | input | 1 | 1: drop early syncs; 0: abort and restart on them |
| data_delay | input | 2 | Idle bit clocks between sync and first data bit (3 acts as 2) |
| hold_valid | input | 1 | Holding register has an unsent element |
| hold_data | input | 8 | Element in the holding register |
| err_clear | input | 1 | Clears the sync error and underflow flags |
| tx_data | output | 1 | Serial data line |
| tx_busy | output | 1 | Frame in progress (delay or data) |
| hold_release | output | 1 | Element committed; producer may refill the holding register |
| sync_err | output | 1 | Sticky transmit sync error |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The bench aims early syncs at the first delay cycle, at a middle data bit and at the edge that ends the last bit. It uses each setting of the skip control. A design that treated the final edge as a legal start would launch a new element instead of flagging an abort. A design that advanced to fresh data on an abort would show a different bit stream from the restarted MSB. The bench also holds the holding register empty at a start, which exposes a design that sends stale bits without raising underflow or that wrongly releases the register. It clears the flags on the same edge as an abort, which catches a clear-wins priority. It drives delay code 3, which catches a design that waits three cycles.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2
    } tfs_state_e;

    typedef enum logic [1:0] {
        FS_NONE  = 2'd0,
        FS_START = 2'd1,
        FS_SKIP  = 2'd2,
        FS_ABORT = 2'd3
    } tfs_fs_kind_e;

endpackage

// File: rtl/tfs_fs_classify.sv
module tfs_fs_classify
    import tfs_pkg::*;
(
    input  logic         fs_seen,
    input  logic         frame_busy,
    input  logic         skip_early,
    output tfs_fs_kind_e kind
);

    always_comb begin
        if (!fs_seen) begin
            kind = FS_NONE;
        end else if (!frame_busy) begin
            kind = FS_START;
        end else if (skip_early) begin
            kind = FS_SKIP;
        end else begin
            kind = FS_ABORT;
        end
    end

endmodule

// File: rtl/tfs_elem_pick.sv
module tfs_elem_pick #(
    parameter int W = 8
) (
    input  logic         start,
    input  logic         hold_valid,
    input  logic [W-1:0] hold_data,
    input  logic [W-1:0] cur_elem,
    output logic [W-1:0] elem,
    output logic         from_hold,
    output logic         starve
);

    // a start takes the holding register when it is full, otherwise the
    // element already on record is used again
    always_comb begin
        from_hold = start && hold_valid;
        starve    = start && !hold_valid;
        elem      = from_hold ? hold_data : cur_elem;
    end

endmodule

// File: rtl/tfs_sticky_flag.sv
module tfs_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) begin
            flag_d = 1'b0;
        end
        if (set) begin
            flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/tfs_tx_framer.sv
module tfs_tx_framer
    import tfs_pkg::*;
#(
    parameter int   W        = 8,
    parameter int   MAX_DLY  = 2,
    parameter logic IDLE_LVL = 1'b0
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       fs_in,
    input  logic                                       skip_early,
    input  logic [((MAX_DLY < 1) ? 1 : $clog2(MAX_DLY + 1))-1:0] data_delay,
    input  logic                                       hold_valid,
    input  logic [W-1:0]                               hold_data,
    input  logic                                       err_clear,
    output logic                                       tx_data,
    output logic                                       tx_busy,
    output logic                                       hold_release,
    output logic                                       sync_err,
    output logic                                       underflow
);

    localparam int DLY_W = (MAX_DLY < 1) ? 1 : $clog2(MAX_DLY + 1);
    localparam int CNT_W = (W < 2) ? 1 : $clog2(W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

    typedef struct packed {
        tfs_state_e       state;
        logic [DLY_W-1:0] dly;
        logic [CNT_W-1:0] bcnt;
        logic [W-1:0]     shreg;
        logic [W-1:0]     cur;
        logic             from_hold;
    } tfs_regs_t;

    localparam tfs_regs_t REGS_RST = '{
        state:     ST_IDLE,
        dly:       '0,
        bcnt:      '0,
        shreg:     '0,
        cur:       '0,
        from_hold: 1'b0
    };

    tfs_regs_t        r_d, r_q;
    tfs_fs_kind_e     fs_kind;
    logic [DLY_W-1:0] dly_eff;
    logic [W-1:0]     pick_elem;
    logic             pick_from_hold;
    logic             pick_starve;
    logic             start_now;
    logic             abort_now;
    logic             shifting;

    // delay codes above the supported maximum saturate
    generate
        if (MAX_DLY == (1 << DLY_W) - 1) begin : g_dly_full
            assign dly_eff = data_delay;
        end else begin : g_dly_clamp
            assign dly_eff = (data_delay > DLY_W'(MAX_DLY)) ? DLY_W'(MAX_DLY) : data_delay;
        end
    endgenerate

    assign tx_busy  = (r_q.state != ST_IDLE);
    assign shifting = (r_q.state == ST_SHIFT);

    tfs_fs_classify u_classify (
        .fs_seen    (fs_in),
        .frame_busy (tx_busy),
        .skip_early (skip_early),
        .kind       (fs_kind)
    );

    assign start_now = (fs_kind == FS_START);
    assign abort_now = (fs_kind == FS_ABORT);

    tfs_elem_pick #(.W(W)) u_pick (
        .start      (start_now),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .cur_elem   (r_q.cur),
        .elem       (pick_elem),
        .from_hold  (pick_from_hold),
        .starve     (pick_starve)
    );

    tfs_sticky_flag u_sync_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (abort_now),
        .clr   (err_clear),
        .flag  (sync_err)
    );

    tfs_sticky_flag u_unf_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (pick_starve),
        .clr   (err_clear),
        .flag  (underflow)
    );

    always_comb begin
        r_d = r_q;

        // free-running progress of the current frame
        case (r_q.state)
            ST_WAIT: begin
                if (r_q.dly == '0) begin
                    r_d.state = ST_SHIFT;
                    r_d.shreg = r_q.cur;
                    r_d.bcnt  = '0;
                end else begin
                    r_d.dly = r_q.dly - 1'b1;
                end
            end
            ST_SHIFT: begin
                if (r_q.bcnt == LAST_BIT) begin
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.shreg = {r_q.shreg[W-2:0], 1'b0};
                    r_d.bcnt  = r_q.bcnt + 1'b1;
                end
            end
            default: begin
            end
        endcase

        // a new frame takes a fresh element; an abort keeps the old one
        if (start_now) begin
            r_d.cur       = pick_elem;
            r_d.from_hold = pick_from_hold;
        end

        if (start_now || abort_now) begin
            if (dly_eff == '0) begin
                r_d.state = ST_SHIFT;
                r_d.shreg = pick_elem;
                r_d.bcnt  = '0;
            end else begin
                r_d.state = ST_WAIT;
                r_d.dly   = dly_eff - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_data      = shifting ? r_q.shreg[W-1] : IDLE_LVL;
    assign hold_release = shifting && (r_q.bcnt == LAST_BIT) && r_q.from_hold;

endmodule

// File: rtl/tfs_tx_framer_chk.sv
module tfs_tx_framer_chk #(
    parameter logic IDLE_LVL = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic fs_in,
    input logic skip_early,
    input logic hold_valid,
    input logic err_clear,
    input logic tx_data,
    input logic tx_busy,
    input logic hold_release,
    input logic sync_err,
    input logic underflow
);

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_data == IDLE_LVL);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_in && !tx_busy) |=> tx_busy);

    // R6
    abort_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_in && tx_busy && !skip_early) |=> sync_err);

    // R5
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_in && tx_busy && skip_early && !sync_err) |=> !sync_err);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && !err_clear) |=> sync_err);

    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clear && !(fs_in && tx_busy && !skip_early)) |=> !sync_err);

    // R8
    release_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_release |-> tx_busy);

    // R8
    release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_release |=> !hold_release);

    // R9
    underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_in && !tx_busy && !hold_valid) |=> underflow);

    // R9
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !err_clear) |=> underflow);

endmodule

bind tfs_tx_framer tfs_tx_framer_chk #(.IDLE_LVL(IDLE_LVL)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fs_in        (fs_in),
    .skip_early   (skip_early),
    .hold_valid   (hold_valid),
    .err_clear    (err_clear),
    .tx_data      (tx_data),
    .tx_busy      (tx_busy),
    .hold_release (hold_release),
    .sync_err     (sync_err),
    .underflow    (underflow)
);

// File: tb/tfs_tx_framer_test.sv
module tfs_tx_framer_test;

    localparam int W      = 8;
    localparam int CLK_NS = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fs_in = 1'b0;
    logic         skip_early = 1'b0;
    logic [1:0]   data_delay = 2'd0;
    logic         hold_valid = 1'b0;
    logic [W-1:0] hold_data = '0;
    logic         err_clear = 1'b0;
    logic         tx_data, tx_busy, hold_release, sync_err, underflow;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    bit  cmp_on = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    tfs_tx_framer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fs_in        (fs_in),
        .skip_early   (skip_early),
        .data_delay   (data_delay),
        .hold_valid   (hold_valid),
        .hold_data    (hold_data),
        .err_clear    (err_clear),
        .tx_data      (tx_data),
        .tx_busy      (tx_busy),
        .hold_release (hold_release),
        .sync_err     (sync_err),
        .underflow    (underflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: one queue entry per line cycle
    // entry code: bit0 data value, bit1 data slot, bit2 last data bit
    int           mq[$];
    logic [W-1:0] m_cur = '0;
    bit           m_from_hold = 1'b0;
    bit           m_err = 1'b0;
    bit           m_unf = 1'b0;
    bit           m_was_busy;

    function automatic void push_frame(input logic [W-1:0] e, input logic [1:0] dly);
        int d = (dly > 2) ? 2 : int'(dly);
        for (int i = 0; i < d; i++) mq.push_back(0);
        for (int i = W - 1; i >= 0; i--) mq.push_back(2 | int'(e[i]) | ((i == 0) ? 4 : 0));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_cur = '0;
            m_from_hold = 1'b0;
            m_err = 1'b0;
            m_unf = 1'b0;
        end else begin
            m_was_busy = (mq.size() > 0);
            if (m_was_busy) void'(mq.pop_front());
            if (err_clear) begin
                m_err = 1'b0;
                m_unf = 1'b0;
            end
            if (fs_in) begin
                if (!m_was_busy) begin
                    if (hold_valid) begin
                        m_cur = hold_data;
                        m_from_hold = 1'b1;
                    end else begin
                        m_unf = 1'b1;
                        m_from_hold = 1'b0;
                    end
                    push_frame(m_cur, data_delay);
                end else if (!skip_early) begin
                    mq.delete();
                    push_frame(m_cur, data_delay);
                    m_err = 1'b1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            logic e_busy, e_tx, e_rel;
            e_busy = (mq.size() > 0);
            e_tx   = e_busy && ((mq[0] & 2) != 0) && ((mq[0] & 1) != 0);
            e_rel  = e_busy && ((mq[0] & 4) != 0) && m_from_hold;
            check("R3 tx_data", 32'(tx_data), 32'(e_tx));
            check("R10 tx_busy", 32'(tx_busy), 32'(e_busy));
            check("R8 hold_release", 32'(hold_release), 32'(e_rel));
            check("R7 sync_err", 32'(sync_err), 32'(m_err));
            check("R9 underflow", 32'(underflow), 32'(m_unf));
        end
    end

    // one bit clock; the producer empties the holding register on release
    task automatic tick();
        @(negedge clk);
        if (hold_release) hold_valid = 1'b0;
    endtask

    task automatic load(input logic [W-1:0] v);
        hold_data  = v;
        hold_valid = 1'b1;
    endtask

    task automatic fire(input logic skip, input logic [1:0] dly);
        fs_in      = 1'b1;
        skip_early = skip;
        data_delay = dly;
        tick();
        fs_in = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        run(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 tx_data", 32'(tx_data), 32'd0);
        check("R1 tx_busy", 32'(tx_busy), 32'd0);
        check("R1 hold_release", 32'(hold_release), 32'd0);
        check("R1 sync_err", 32'(sync_err), 32'd0);
        check("R1 underflow", 32'(underflow), 32'd0);
        cmp_on = 1'b1;

        // R2 zero delay: MSB appears right after the sync edge
        load(8'hA5);
        fire(1'b0, 2'd0);
        check("R2 d0 first bit", 32'(tx_data), 32'd1);
        run(10);

        // R2 two-cycle delay
        load(8'h81);
        fire(1'b0, 2'd2);
        check("R2 d2 idle 1", 32'(tx_data), 32'd0);
        tick();
        check("R2 d2 idle 2", 32'(tx_data), 32'd0);
        tick();
        check("R2 d2 first bit", 32'(tx_data), 32'd1);
        run(10);

        // R2 delay code 3 acts as 2, delay 1
        load(8'h3C);
        fire(1'b0, 2'd3);
        run(12);
        load(8'hF0);
        fire(1'b0, 2'd1);
        run(11);

        // R5 skipped early sync mid-frame
        load(8'h96);
        fire(1'b0, 2'd0);
        run(3);
        fire(1'b1, 2'd0);
        check("R5 no flag", 32'(sync_err), 32'd0);
        check("R5 still busy", 32'(tx_busy), 32'd1);
        run(8);

        // R6 abort mid-frame, restart same element with zero delay
        load(8'hC3);
        fire(1'b0, 2'd0);
        run(4);
        fire(1'b0, 2'd0);
        check("R6 flag", 32'(sync_err), 32'd1);
        check("R6 restart MSB", 32'(tx_data), 32'd1);
        run(10);

        // R7 clear, then clear coinciding with an abort
        err_clear = 1'b1;
        tick();
        err_clear = 1'b0;
        check("R7 cleared", 32'(sync_err), 32'd0);
        load(8'h5A);
        fire(1'b0, 2'd1);
        run(2);
        err_clear = 1'b1;
        fire(1'b0, 2'd2);
        err_clear = 1'b0;
        check("R7 set wins", 32'(sync_err), 32'd1);
        run(12);

        // R4 sync on the edge that ends the last bit is early
        err_clear = 1'b1;
        tick();
        err_clear = 1'b0;
        load(8'h7E);
        fire(1'b0, 2'd0);
        while (!hold_release) tick();
        fire(1'b0, 2'd0);
        check("R4 last-edge abort", 32'(sync_err), 32'd1);
        run(10);

        // R9 start with an empty holding register
        hold_valid = 1'b0;
        fire(1'b0, 2'd0);
        check("R9 underflow", 32'(underflow), 32'd1);
        check("R9 no release", 32'(hold_release), 32'd0);
        run(10);

        // R6 abort during the delay phase
        load(8'h1F);
        fire(1'b0, 2'd2);
        fire(1'b0, 2'd2);
        run(12);

        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            if (!hold_valid && ($urandom % 3) != 0) load(W'($urandom));
            fs_in      = (($urandom % 7) == 0);
            skip_early = ($urandom % 2) != 0;
            data_delay = 2'($urandom % 4);
            err_clear  = (($urandom % 25) == 0);
            tick();
        end
        fs_in = 1'b0;
        err_clear = 1'b0;
        run(15);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R10 act=running exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule